// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block cleans up one general-purpose input pin before the rest of the chip sees it. The raw pad level is first brought into the core clock domain by a two-stage synchronizer. A filter stage then decides when a change of level may reach the output. The filter measures time in ticks of a slow real-time clock, which arrive as a one-cycle enable in the core clock domain.

Software programs three things: a unit of time, a count of units and a filter type. The unit is picked by two bits and ranges from 2 to 2048 ticks. With a 32.768 kHz tick source, the longest debounce time is about one second.

There are three filter types. One requires a new level to hold steady for the whole debounce time before it is accepted in either direction. The other two pass edges of one polarity through at once and filter only the opposite edge, so short pulses of the favoured polarity survive. A filter type of zero bypasses the filter entirely.

A settled flag reports when the output has caught up with the synchronized input and no qualification is in progress.

Top module: `gpio_debounce`

## Requirements
- R1: During and directly after reset, `pin_db` is 0 and `settled` is 1.
- R2: With `filt_ctl` = 0 (bypass), `pin_db` takes the value `pin_raw` had before the third rising clock edge after it changed. `unit_large`, `unit_fine` and `tick_count` have no effect in this mode.
- R3: With `filt_ctl` = 3 (both edges filtered) and a tick on every cycle, a level held on `pin_raw` reaches `pin_db` at clock edge 2+L after the change, where L is the debounce length in ticks.
- R4: In a filtered direction, any reversal before the length completes restarts the timer. A pulse seen for L−1 ticks never reaches `pin_db`; a pulse seen for exactly L ticks does.
- R5: L = max(`tick_count`,1) × U. U is selected by {`unit_large`,`unit_fine`}: 00 gives 2, 01 gives 8, 10 gives 512 and 11 gives 2048 ticks.
- R6: A `tick_count` of 0 gives the same length as a count of 1.
- R7: `settled` is 0 while the synchronized input differs from `pin_db` or a qualification count is running. It is 1 once they agree and the timer is idle.
- R8: The qualification timer advances only on cycles where `rtc_tick` is 1. Without ticks, a pending change never reaches `pin_db`.
- R9: With `filt_ctl` = 1 (keep low pulses), a falling level reaches `pin_db` at edge 3 after the change, and a rising level is filtered as in R3.
- R10: With `filt_ctl` = 2 (keep high pulses), a rising level reaches `pin_db` at edge 3 after the change, and a falling level is filtered as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | 1 | Unsynchronized pad level |
| rtc_tick | input | 1 | One-cycle enable per real-time clock tick |
| unit_large | input | 1 | High bit of the time-unit select |
| unit_fine | input | 1 | Low bit of the time-unit select |
| tick_count | input | CNT_W | Number of time units (0 treated as 1) |
| filt_ctl | input | 2 | Filter type: 0 bypass, 1 keep low pulses, 2 keep high pulses, 3 filter both edges |
| pin_db | output | 1 | Debounced level |
| settled | output | 1 | Output agrees with synchronized input and timer idle |

## Verification
The case that matters most is a timer expiry and an input reversal landing on the same clock edge. The design must let the reversal win, so the output does not flip.

The bench provokes this by sending pulses of exactly L−1 and exactly L ticks. The shorter pulse must leave the output unchanged, and the longer one must make it flip at edge 2+L.

In the keep-pulse modes, a fast pass-through edge can also meet a qualification that is counting in the other direction. The bench sends a one-cycle glitch of the favoured polarity and checks two things: the output follows the glitch at edge 3, and the return edge is then held back for the full length.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
  typedef enum logic [1:0] {
    FILT_OFF     = 2'd0,
    FILT_KEEP_LO = 2'd1,
    FILT_KEEP_HI = 2'd2,
    FILT_BOTH    = 2'd3
  } filt_e;

  // Qualification length in ticks: a count of zero still takes one unit.
  function automatic int unsigned span_ticks(int unsigned unit, int unsigned count);
    return ((count == 0) ? 1 : count) * unit;
  endfunction
endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gdb_span.sv
module gdb_span #(
  parameter int CNT_W = 4,
  parameter int LIM_W = 15,
  parameter int U00   = 2,
  parameter int U01   = 8,
  parameter int U10   = 512,
  parameter int U11   = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_large,
  input  logic             unit_fine,
  input  logic [CNT_W-1:0] count,
  output logic [LIM_W-1:0] limit
);
  import gdb_pkg::*;

  int unsigned unit_sel;

  always_comb begin
    case ({unit_large, unit_fine})
      2'b00:   unit_sel = U00;
      2'b01:   unit_sel = U01;
      2'b10:   unit_sel = U10;
      default: unit_sel = U11;
    endcase
    limit = LIM_W'(span_ticks(unit_sel, int'(count)));
  end

  // R6
  limit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limit != '0);
endmodule

// File: rtl/gdb_timer.sv
module gdb_timer #(
  parameter int LIM_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit,
  output logic             expire,
  output logic             busy
);
  logic [LIM_W-1:0] cnt;

  assign expire = run && tick && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});
  assign busy   = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= expire ? '0 : cnt + 1'b1;
  end

  // R4
  ctr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (cnt == '0));
  // R8
  ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(tick)) |-> (cnt == $past(cnt)));
endmodule

// File: rtl/gdb_filter.sv
module gdb_filter
  import gdb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  filt_e mode,
  input  logic  lvl,
  input  logic  expire,
  output logic  run,
  output logic  fast,
  output logic  dout
);
  logic mismatch;

  always_comb begin
    mismatch = (lvl != dout);
    fast     = mismatch && (((mode == FILT_KEEP_LO) && !lvl) ||
                            ((mode == FILT_KEEP_HI) &&  lvl));
    run      = mismatch && (mode != FILT_OFF) && !fast;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 1'b0;
    else if ((mode == FILT_OFF) || fast || expire) dout <= lvl;
  end

  // R9
  plow_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode == FILT_KEEP_LO) && !$past(lvl)) |-> !dout);
  // R10
  phigh_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode == FILT_KEEP_HI) && $past(lvl)) |-> dout);
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int U00         = 2,
  parameter int U01         = 8,
  parameter int U10         = 512,
  parameter int U11         = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_raw,
  input  logic             rtc_tick,
  input  logic             unit_large,
  input  logic             unit_fine,
  input  logic [CNT_W-1:0] tick_count,
  input  logic [1:0]       filt_ctl,
  output logic             pin_db,
  output logic             settled
);
  import gdb_pkg::*;

  localparam int MAX_LIM = ((1 << CNT_W) - 1) * U11;
  localparam int LIM_W   = $clog2(MAX_LIM + 1);

  logic             lvl;
  logic             run;
  logic             fast;
  logic             expire;
  logic             busy;
  logic [LIM_W-1:0] limit;
  filt_e            mode;

  assign mode = filt_e'(filt_ctl);

  gdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(lvl)
  );

  gdb_span #(.CNT_W(CNT_W), .LIM_W(LIM_W), .U00(U00), .U01(U01),
             .U10(U10), .U11(U11)) u_span (
    .clk(clk), .rst_n(rst_n), .unit_large(unit_large), .unit_fine(unit_fine),
    .count(tick_count), .limit(limit)
  );

  gdb_timer #(.LIM_W(LIM_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(rtc_tick),
    .limit(limit), .expire(expire), .busy(busy)
  );

  gdb_filter u_filter (
    .clk(clk), .rst_n(rst_n), .mode(mode), .lvl(lvl), .expire(expire),
    .run(run), .fast(fast), .dout(pin_db)
  );

  assign settled = !busy && (lvl == pin_db);

  // R2
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode == FILT_OFF) |-> (pin_db == $past(lvl)));
  // R3
  remove_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode == FILT_BOTH) && (pin_db != $past(pin_db))) |->
      ($past(rtc_tick) && ($past(lvl) == pin_db)));
  // R7
  settled_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (pin_db == lvl));
endmodule

// File: tb/gpio_debounce_bench.sv
module gpio_debounce_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b0;
  logic       rtc_tick = 1'b1;
  logic       unit_large = 1'b0;
  logic       unit_fine = 1'b0;
  logic [3:0] tick_count = 4'd0;
  logic [1:0] filt_ctl = 2'd0;
  logic       pin_db;
  logic       settled;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_debounce u_gpio_debounce (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .rtc_tick(rtc_tick),
    .unit_large(unit_large), .unit_fine(unit_fine), .tick_count(tick_count),
    .filt_ctl(filt_ctl), .pin_db(pin_db), .settled(settled)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_len(bit lg, bit fn, int c);
    int u;
    if (lg) u = fn ? 2048 : 512;
    else    u = fn ? 8 : 2;
    return ((c == 0) ? 1 : c) * u;
  endfunction

  task automatic cfg(bit lg, bit fn, int c, int ctl);
    unit_large = lg; unit_fine = fn; tick_count = 4'(c); filt_ctl = 2'(ctl);
    step(40);
  endtask

  task automatic t_reset();
    chk("R1 pin_db", pin_db, 1'b0);
    chk("R1 settled", settled, 1'b1);
  endtask

  task automatic t_bypass();
    cfg(1, 1, 5, 0);
    pin_raw = 1'b1; step(2);
    chk("R2 before third edge", pin_db, 1'b0);
    step(1);
    chk("R2 follows", pin_db, 1'b1);
    pin_raw = 1'b0; step(3);
    chk("R2 follows low", pin_db, 1'b0);
  endtask

  task automatic t_remove();
    cfg(0, 0, 3, 3);
    pin_raw = 1'b1; step(2);
    chk("R7 settled pending", settled, 1'b0);
    step(5);
    chk("R3 held before 2+L", pin_db, 1'b0);
    step(1);
    chk("R3 flips at 2+L", pin_db, 1'b1);
    chk("R7 settled after", settled, 1'b1);
  endtask

  task automatic t_reversal();
    pin_raw = 1'b0; step(5); pin_raw = 1'b1; step(12);
    chk("R4 pulse L-1 rejected", pin_db, 1'b1);
    pin_raw = 1'b0; step(6); pin_raw = 1'b1; step(2);
    chk("R4 pulse L accepted", pin_db, 1'b0);
    step(12);
    chk("R4 returns high", pin_db, 1'b1);
  endtask

  task automatic t_span(bit lg, bit fn, int c, string req);
    int len;
    logic tgt;
    cfg(lg, fn, c, 3);
    len = exp_len(lg, fn, c);
    tgt = ~pin_db;
    pin_raw = tgt; step(1 + len);
    chk(req, pin_db, ~tgt);
    step(1);
    chk(req, pin_db, tgt);
  endtask

  task automatic t_tick();
    logic old;
    cfg(0, 0, 1, 3);
    old = pin_db;
    rtc_tick = 1'b0; pin_raw = ~old; step(50);
    chk("R8 no tick no change", pin_db, old);
    chk("R8 settled low while pending", settled, 1'b0);
    rtc_tick = 1'b1; step(1);
    chk("R8 one tick", pin_db, old);
    step(1);
    chk("R8 second tick flips", pin_db, ~old);
  endtask

  task automatic t_plow();
    cfg(0, 0, 3, 1);
    pin_raw = 1'b1; step(20);
    pin_raw = 1'b0; step(1); pin_raw = 1'b1; step(2);
    chk("R9 low glitch passes", pin_db, 1'b0);
    step(3);
    chk("R9 rise filtered", pin_db, 1'b0);
    step(10);
    chk("R9 rise accepted", pin_db, 1'b1);
    pin_raw = 1'b0; step(20);
    pin_raw = 1'b1; step(5); pin_raw = 1'b0; step(12);
    chk("R9 short high rejected", pin_db, 1'b0);
  endtask

  task automatic t_phigh();
    cfg(0, 0, 3, 2);
    pin_raw = 1'b0; step(20);
    pin_raw = 1'b1; step(1); pin_raw = 1'b0; step(2);
    chk("R10 high glitch passes", pin_db, 1'b1);
    step(3);
    chk("R10 fall filtered", pin_db, 1'b1);
    step(10);
    chk("R10 fall accepted", pin_db, 1'b0);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_bypass();
    t_remove();
    t_reversal();
    t_span(0, 0, 15, "R5 unit 2 x15");
    t_span(0, 1, 0, "R6 count zero");
    t_span(0, 1, 2, "R5 unit 8 x2");
    t_span(1, 0, 1, "R5 unit 512");
    t_span(1, 1, 1, "R5 unit 2048");
    t_tick();
    t_plow();
    t_phigh();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule